// File: doc/BRIEF.md
# Programmable Product-Term Array

This block is the AND plane of a small programmable sequencer. It forms 32 product terms, each an AND of selected literals taken from four dedicated inputs, four inputs sampled from bidirectional pins, eight register feedback bits and one shared complement signal. Every literal is chosen by a two-bit link code. The code can pass the variable true, pass it inverted, drop it as a don't-care, or leave it intact. An intact code kills the whole term. The complement signal is the NOR of every term marked as a generator. It returns to all terms as one more literal. The OR plane, the registers and the pin drivers sit in neighbouring blocks and take `term_o` and `comp_o` as their inputs.

Configuration lives in flops, loaded 16 bits at a time through an address/data/write-enable port. Each term occupies a stride of four addresses. Word 0 holds the link codes of variables 0 to 7, word 1 holds those of variables 8 to 15, and word 2 is a control word. Word 3 is unused. The term outputs are combinational from the inputs and the stored configuration. A term that both generates the complement signal and consumes it would form an oscillating loop. Such a term is forced to 0, and it raises a sticky error flag.

Top module: `pta_top`

## Requirements
- R1: While reset is low and after it is released, every stored code is 00 and every generator bit is 0. Therefore `term_o` is all zeros, `comp_o` is 1 and `cfg_err_o` is 0.
- R2: The literal factor for link code c and variable x is: 01 gives x, 10 gives NOT x, 11 gives 1. A term is the AND of the factors of all 16 variables and of the complement literal.
- R3: A term is 0 for every input value when any one of its link codes is 00.
- R4: The variable index is v. Dedicated input k is v = k, pin input k is v = 4 + k, and feedback bit k is v = 8 + k. The code for v sits at bits [2v+1:2v] of the term's 32-bit link vector. Address {term[4:0], word[1:0]} with word 0 writes link bits [15:0], and word 1 writes link bits [31:16].
- R5: `comp_o` is the NOR of all terms whose generator bit is 1. When no term generates, `comp_o` is 1.
- R6: Control word bits [1:0] hold the link code of the complement literal in that term, with the same encoding as R2. Bit 2 is the term's generator bit.
- R7: A term with generator bit 1 and a complement code other than 11 is illegal. Its output is 0 and it does not pull `comp_o` low. `cfg_err_o` rises at the first clock edge after the illegal state is stored, and it stays 1 until reset.
- R8: A write with word index 3 changes no term output and no stored state.
- R9: `term_o` and `comp_o` follow input changes in the same cycle without a clock edge. They reflect a write from the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration store and error flag |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Configuration address {term, word} |
| cfg_wdata_i | input | 16 | Configuration write data |
| ded_i | input | 4 | Dedicated inputs |
| bio_i | input | 4 | Inputs taken from bidirectional pins |
| fb_i | input | 8 | Register feedback bits |
| term_o | output | 32 | Product term values |
| comp_o | output | 1 | Complement signal (NOR of generator terms) |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
Terms and the complement signal are due within the same cycle as an input change. For a write, they are due from the edge that stores the word. The bench therefore drives inputs and writes on the falling edge and samples 2 ns later, well before the next rising edge. The error flag takes one edge more. After an illegal control word is stored, the bench samples it at the next falling edge and expects it still low. It samples again one falling edge later and expects it high. It then samples it after a legal rewrite and expects it still high.

// File: rtl/pta_pkg.sv
package pta_pkg;

    // Two-bit link code applied to each literal of a product term
    typedef enum logic [1:0] {
        LINK_INTACT = 2'b00,   // term inhibited
        LINK_TRUE   = 2'b01,   // variable used as is
        LINK_COMP   = 2'b10,   // variable used inverted
        LINK_OPEN   = 2'b11    // variable ignored
    } link_e;

    localparam int CTRL_CIN_LSB = 0;
    localparam int CTRL_GEN_BIT = 2;

    // Factor contributed by one literal: bit0 admits the true value,
    // bit1 admits the inverted value.
    function automatic logic link_factor(input logic [1:0] code, input logic x);
        return (code[0] & x) | (code[1] & ~x);
    endfunction

endpackage

// File: rtl/pta_cfg_regs.sv
module pta_cfg_regs #(
    parameter int NUM_TERMS = 32,
    parameter int NUM_VAR   = 16,
    parameter int CFG_W     = 16,
    parameter int ADDR_W    = 7
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  we_i,
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic [CFG_W-1:0]                      wdata_i,
    input  logic [NUM_TERMS-1:0]                  illegal_i,
    output logic [NUM_TERMS-1:0][2*NUM_VAR-1:0]   link_o,
    output logic [NUM_TERMS-1:0][1:0]             cin_o,
    output logic [NUM_TERMS-1:0]                  gen_o,
    output logic                                  err_o
);
    import pta_pkg::*;

    localparam int LINK_W      = 2 * NUM_VAR;
    localparam int LINK_WORDS  = LINK_W / CFG_W;
    localparam int WORD_SEL_W  = $clog2(LINK_WORDS + 1);
    localparam int TERM_SEL_W  = ADDR_W - WORD_SEL_W;

    typedef struct packed {
        logic [NUM_TERMS-1:0][LINK_W-1:0] link;
        logic [NUM_TERMS-1:0][1:0]        cin;
        logic [NUM_TERMS-1:0]             gen;
        logic                             err;
    } state_t;

    state_t st_d, st_q;

    logic [TERM_SEL_W-1:0] term_sel;
    logic [WORD_SEL_W-1:0] word_sel;

    assign term_sel = addr_i[ADDR_W-1 -: TERM_SEL_W];
    assign word_sel = addr_i[WORD_SEL_W-1:0];

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            for (int w = 0; w < LINK_WORDS; w++) begin
                if (word_sel == WORD_SEL_W'(w)) begin
                    st_d.link[term_sel][w*CFG_W +: CFG_W] = wdata_i;
                end
            end
            if (word_sel == WORD_SEL_W'(LINK_WORDS)) begin
                st_d.cin[term_sel] = wdata_i[CTRL_CIN_LSB +: 2];
                st_d.gen[term_sel] = wdata_i[CTRL_GEN_BIT];
            end
        end
        st_d.err = st_q.err | (|illegal_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign link_o = st_q.link;
    assign cin_o  = st_q.cin;
    assign gen_o  = st_q.gen;
    assign err_o  = st_q.err;

endmodule

// File: rtl/pta_term_plane.sv
module pta_term_plane #(
    parameter int NUM_TERMS = 32,
    parameter int NUM_VAR   = 16
) (
    input  logic [NUM_VAR-1:0]                    vars_i,
    input  logic [NUM_TERMS-1:0][2*NUM_VAR-1:0]   link_i,
    output logic [NUM_TERMS-1:0]                  base_o
);
    import pta_pkg::*;

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic acc;
        always_comb begin
            acc = 1'b1;
            for (int v = 0; v < NUM_VAR; v++) begin
                acc = acc & link_factor(link_i[t][2*v +: 2], vars_i[v]);
            end
        end
        assign base_o[t] = acc;
    end

endmodule

// File: rtl/pta_comp_array.sv
module pta_comp_array #(
    parameter int NUM_TERMS = 32
) (
    input  logic [NUM_TERMS-1:0]       base_i,
    input  logic [NUM_TERMS-1:0][1:0]  cin_i,
    input  logic [NUM_TERMS-1:0]       gen_i,
    output logic [NUM_TERMS-1:0]       term_o,
    output logic                       comp_o,
    output logic [NUM_TERMS-1:0]       illegal_o
);
    import pta_pkg::*;

    logic [NUM_TERMS-1:0] drivers;

    // A legal generator has an open complement literal, so its value is
    // the base product alone; the NOR therefore needs no feedback path.
    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_legal
        assign illegal_o[t] = gen_i[t] & (cin_i[t] != LINK_OPEN);
        assign drivers[t]   = gen_i[t] & ~illegal_o[t] & base_i[t];
    end

    assign comp_o = ~(|drivers);

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_out
        assign term_o[t] = base_i[t] & link_factor(cin_i[t], comp_o) & ~illegal_o[t];
    end

endmodule

// File: rtl/pta_top.sv
module pta_top #(
    parameter int NUM_DED   = 4,
    parameter int NUM_BIO   = 4,
    parameter int NUM_FB    = 8,
    parameter int NUM_TERMS = 32,
    parameter int CFG_W     = 16,
    parameter int ADDR_W    = $clog2(NUM_TERMS)
                            + $clog2((2 * (NUM_DED + NUM_BIO + NUM_FB)) / CFG_W + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cfg_we_i,
    input  logic [ADDR_W-1:0]     cfg_addr_i,
    input  logic [CFG_W-1:0]      cfg_wdata_i,
    input  logic [NUM_DED-1:0]    ded_i,
    input  logic [NUM_BIO-1:0]    bio_i,
    input  logic [NUM_FB-1:0]     fb_i,
    output logic [NUM_TERMS-1:0]  term_o,
    output logic                  comp_o,
    output logic                  cfg_err_o
);
    localparam int NUM_VAR = NUM_DED + NUM_BIO + NUM_FB;
    localparam int LINK_W  = 2 * NUM_VAR;

    logic [NUM_VAR-1:0]                  vars_w;
    logic [NUM_TERMS-1:0][LINK_W-1:0]    link_w;
    logic [NUM_TERMS-1:0][1:0]           cin_w;
    logic [NUM_TERMS-1:0]                gen_w;
    logic [NUM_TERMS-1:0]                base_w;
    logic [NUM_TERMS-1:0]                illegal_w;

    assign vars_w = {fb_i, bio_i, ded_i};

    pta_cfg_regs #(
        .NUM_TERMS (NUM_TERMS),
        .NUM_VAR   (NUM_VAR),
        .CFG_W     (CFG_W),
        .ADDR_W    (ADDR_W)
    ) cfg_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .illegal_i (illegal_w),
        .link_o    (link_w),
        .cin_o     (cin_w),
        .gen_o     (gen_w),
        .err_o     (cfg_err_o)
    );

    pta_term_plane #(
        .NUM_TERMS (NUM_TERMS),
        .NUM_VAR   (NUM_VAR)
    ) plane_i (
        .vars_i    (vars_w),
        .link_i    (link_w),
        .base_o    (base_w)
    );

    pta_comp_array #(
        .NUM_TERMS (NUM_TERMS)
    ) comp_i (
        .base_i    (base_w),
        .cin_i     (cin_w),
        .gen_i     (gen_w),
        .term_o    (term_o),
        .comp_o    (comp_o),
        .illegal_o (illegal_w)
    );

endmodule

// File: rtl/pta_checker.sv
module pta_checker #(
    parameter int NUM_TERMS = 32,
    parameter int LINK_W    = 32
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic [NUM_TERMS-1:0]               term_o,
    input  logic                               comp_o,
    input  logic                               cfg_err_o,
    input  logic [NUM_TERMS-1:0][LINK_W-1:0]   link_q,
    input  logic [NUM_TERMS-1:0][1:0]          cin_q,
    input  logic [NUM_TERMS-1:0]               gen_q
);
    localparam int NUM_VAR = LINK_W / 2;

    logic [NUM_TERMS-1:0] bad;
    logic [NUM_TERMS-1:0] has_intact;

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_chk
        always_comb begin
            has_intact[t] = 1'b0;
            for (int v = 0; v < NUM_VAR; v++) begin
                if (link_q[t][2*v +: 2] == 2'b00) has_intact[t] = 1'b1;
            end
        end
        assign bad[t] = gen_q[t] && (cin_q[t] != 2'b11);

        AST_INTACT_TERM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            has_intact[t] |-> !term_o[t]); // R3
        AST_CIN_INTACT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cin_q[t] == 2'b00) |-> !term_o[t]); // R6
        AST_ILLEGAL_TERM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            bad[t] |-> !term_o[t]); // R7
    end

    AST_COMP_IS_NOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        comp_o == !(|(term_o & gen_q))); // R5
    AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|bad) |=> cfg_err_o); // R7
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> cfg_err_o); // R7

endmodule

bind pta_top pta_checker #(
    .NUM_TERMS (NUM_TERMS),
    .LINK_W    (LINK_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .term_o    (term_o),
    .comp_o    (comp_o),
    .cfg_err_o (cfg_err_o),
    .link_q    (link_w),
    .cin_q     (cin_w),
    .gen_q     (gen_w)
);

// File: tb/pta_top_tb_top.sv
`timescale 1ns/1ps
module pta_top_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [6:0]  cfg_addr_i = '0;
    logic [15:0] cfg_wdata_i = '0;
    logic [3:0]  ded_i = '0;
    logic [3:0]  bio_i = '0;
    logic [7:0]  fb_i = '0;
    logic [31:0] term_o;
    logic        comp_o;
    logic        cfg_err_o;

    int total = 0;
    int bad = 0;

    always #5 clk_i = ~clk_i;

    pta_top dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .ded_i       (ded_i),
        .bio_i       (bio_i),
        .fb_i        (fb_i),
        .term_o      (term_o),
        .comp_o      (comp_o),
        .cfg_err_o   (cfg_err_o)
    );

    // {ded, bio, fb, expected term[6:0], expected comp}
    // t0=d0&~d1  t1=f7&~b2 (gen)  t2=C  t3=d3 (gen)  t4=~C  t5=0  t6=1
    localparam logic [23:0] VECS [0:7] = '{
        {4'h0, 4'h0, 8'h00, 7'b1000100, 1'b1},
        {4'h1, 4'h0, 8'h00, 7'b1000101, 1'b1},
        {4'h3, 4'h0, 8'h00, 7'b1000100, 1'b1},
        {4'h8, 4'h0, 8'h00, 7'b1011000, 1'b0},
        {4'h0, 4'h0, 8'h80, 7'b1010010, 1'b0},
        {4'h0, 4'h4, 8'h80, 7'b1000100, 1'b1},
        {4'h9, 4'h0, 8'h80, 7'b1011011, 1'b0},
        {4'h4, 4'hB, 8'hFF, 7'b1010010, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk_i);
        cfg_we_i = 1'b1;
        cfg_addr_i = a;
        cfg_wdata_i = d;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: state during and after reset
        repeat (3) @(negedge clk_i);
        #2;
        check("R1", "term in reset", term_o, 32'h0);
        check("R1", "comp in reset", {31'b0, comp_o}, 32'h1);
        check("R1", "err in reset", {31'b0, cfg_err_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        #2;
        check("R1", "term after reset", term_o, 32'h0);
        check("R1", "comp after reset", {31'b0, comp_o}, 32'h1);

        // Configuration of terms 0..6, address = term*4 + word (R4, R6)
        wr(7'd0,  16'hFFF9); wr(7'd1,  16'hFFFF); wr(7'd2,  16'h0003);
        wr(7'd4,  16'hEFFF); wr(7'd5,  16'h7FFF); wr(7'd6,  16'h0007);
        wr(7'd8,  16'hFFFF); wr(7'd9,  16'hFFFF); wr(7'd10, 16'h0001);
        wr(7'd12, 16'hFF7F); wr(7'd13, 16'hFFFF); wr(7'd14, 16'h0007);
        wr(7'd16, 16'hFFFF); wr(7'd17, 16'hFFFF); wr(7'd18, 16'h0002);
        wr(7'd20, 16'hFFDF); wr(7'd21, 16'hFFFC); wr(7'd22, 16'h0003);
        wr(7'd24, 16'hFFFF); wr(7'd25, 16'hFFFF); wr(7'd26, 16'h0003);
        @(negedge clk_i);
        #2;
        check("R7", "no error on legal config", {31'b0, cfg_err_o}, 32'h0);

        // R8: word index 3 writes are ignored
        wr(7'd31, 16'hFFFF);
        wr(7'd27, 16'h0000);

        // Table walk: R2, R3, R4, R5, R6, R8, R9
        for (int i = 0; i < 8; i++) begin
            @(negedge clk_i);
            {ded_i, bio_i, fb_i} = VECS[i][23:8];
            #2;
            check("R2_R4_R6", $sformatf("vec %0d terms", i), {25'b0, term_o[6:0]},
                  {25'b0, VECS[i][7:1]});
            check("R3_R8", $sformatf("vec %0d upper terms", i), {7'b0, term_o[31:7]}, 32'h0);
            check("R5", $sformatf("vec %0d comp", i), {31'b0, comp_o}, {31'b0, VECS[i][0]});
        end

        // R9: combinational response between clock edges
        @(posedge clk_i);
        #1;
        ded_i = 4'h1; bio_i = 4'h0; fb_i = 8'h00;
        #1;
        check("R9", "term0 without edge", {31'b0, term_o[0]}, 32'h1);
        ded_i = 4'h0;
        #1;
        check("R9", "term0 falls without edge", {31'b0, term_o[0]}, 32'h0);

        // R7: illegal term 8 (generator with true complement literal)
        wr(7'd32, 16'hFFFF);
        wr(7'd33, 16'hFFFF);
        wr(7'd34, 16'h0005);
        #2;
        check("R7", "illegal term forced low", {31'b0, term_o[8]}, 32'h0);
        check("R7", "illegal term not in NOR", {31'b0, comp_o}, 32'h1);
        check("R7", "err not yet set", {31'b0, cfg_err_o}, 32'h0);
        @(negedge clk_i);
        #2;
        check("R7", "err set one edge later", {31'b0, cfg_err_o}, 32'h1);
        wr(7'd34, 16'h0003);
        #2;
        check("R7", "term8 legal non-generator", {31'b0, term_o[8]}, 32'h1);
        check("R7", "err sticky", {31'b0, cfg_err_o}, 32'h1);
        wr(7'd34, 16'h0007);
        #2;
        check("R5", "legal generator pulls comp low", {31'b0, comp_o}, 32'h0);
        check("R6", "terms using C", {27'b0, term_o[8], term_o[4], term_o[2], 2'b00},
              {27'b0, 1'b1, 1'b1, 1'b0, 2'b00});

        // R1: reset clears configuration and flag
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        #2;
        check("R1", "term after second reset", term_o, 32'h0);
        check("R1", "comp after second reset", {31'b0, comp_o}, 32'h1);
        check("R1", "err after second reset", {31'b0, cfg_err_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule